// File: doc/BRIEF.md
# Infrared Run-Length Sampler

This block sits behind a demodulating infrared receiver and turns its single digital output into a stream of run-length bytes. A base clock is divided down to a sample tick. The line can be inverted so that a mark always reads as 1. Short excursions are filtered out, and every run of constant level is measured in ticks. Each finished run leaves the block as one byte: the level sits in the top bit and the length in ticks sits in the low seven bits. A packet-end strobe follows once the line has stayed at space for a programmable window.

A downstream buffer or decoder takes the bytes over a valid/ready interface. A byte on the output stays put until it is accepted. The block has no storage beyond that single output register. Any run that completes while the register still holds an unaccepted byte is discarded. The consumer must therefore accept each byte within one sample tick if no data is to be lost. Configuration fields and enables are plain static inputs.

Top module: `ir_runlen_sampler`

## Requirements
- R1: The sample tick occurs once every 2^DIV_LOG base clocks when `cfg_slow` is 0, and once every 2^(DIV_LOG+1) base clocks when it is 1. The defaults are 64 and 128. All run lengths count ticks.
- R2: Each output byte carries the level in bit 7 (1 = mark, 0 = space) and the run length in ticks in bits 6:0. Every byte has a nonzero length.
- R3: When `cfg_invert` is 1, the line is inverted before sampling. A line held high then reads as space.
- R4: A level change is accepted only after the new level has been sampled on max(`cfg_filter`,1) consecutive ticks. A shorter excursion is counted into the run it interrupts. An accepted change does not alter the measured run lengths.
- R5: A run longer than 126 ticks produces a byte of length 127 each time 127 ticks have accumulated, and counting of the same level restarts from zero. A run that is an exact multiple of 127 produces no zero-length byte.
- R6: No byte is produced while the line is at space before the first mark of a packet.
- R7: When (`cfg_idle`+1)*128 consecutive space ticks have been counted, the remainder of the current space run is emitted as a byte. `pkt_end` then pulses high for one clock, exactly one clock after that byte first appears.
- R8: The block runs only while `glob_en` and `rx_en` are both 1. Otherwise all sampling, filter and run state is cleared, and `smp_valid` and `pkt_end` stay low.
- R9: While `smp_valid` is high and `smp_ready` is low, `smp_valid` and `smp_data` hold their values. A run completed in that time is discarded.
- R10: After a packet end, the block waits for the next mark and begins a new packet without any re-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| ir_line | input | 1 | Demodulated receiver output, asynchronous |
| glob_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive enable |
| cfg_slow | input | 1 | 0 selects the short tick period, 1 the long one |
| cfg_invert | input | 1 | Invert the line before sampling |
| cfg_filter | input | FILT_W | Minimum accepted run, in ticks |
| cfg_idle | input | IDLE_W | Idle window N; packet ends after (N+1)*128 space ticks |
| smp_ready | input | 1 | Consumer accepts the byte on this clock |
| smp_valid | output | 1 | Output byte is valid |
| smp_data | output | 8 | Level (bit 7) and run length (bits 6:0) |
| pkt_end | output | 1 | One-clock packet-end pulse |

## Verification
The assertions assume that the configuration inputs stay static while the block is enabled. They also assume that `smp_ready` is driven only from clocked logic, so the hold property sees a clean handshake. The stimulus changes configuration only while both enables are low. Line edges are placed halfway between ticks, so the two-flop synchronizer never puts a ticks-count on a boundary. Every space inside a packet is kept shorter than the idle window, so the bench alone decides where each packet ends.

// File: rtl/irrl_pkg.sv
package irrl_pkg;
  localparam int RL_LEN_W = 7;
  localparam int RL_MAX   = (1 << RL_LEN_W) - 1;

  typedef struct packed {
    logic                mark;
    logic [RL_LEN_W-1:0] len;
  } rl_byte_t;
endpackage

// File: rtl/irrl_tick_div.sv
module irrl_tick_div #(
  parameter int DIV_LOG = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic slow,
  output logic tick
);
  localparam int CW = DIV_LOG + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = slow ? CW'((2 << DIV_LOG) - 1) : CW'((1 << DIV_LOG) - 1);
  assign tick = run && (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  // R1
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/irrl_glitch_filter.sv
module irrl_glitch_filter #(
  parameter int THR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             din,
  input  logic [THR_W-1:0] thr,
  output logic             level
);
  logic [THR_W-1:0] cand;
  logic [THR_W:0]   need;
  logic [THR_W:0]   cand_inc;

  assign need     = (thr == '0) ? (THR_W+1)'(1) : {1'b0, thr};
  assign cand_inc = {1'b0, cand} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      level <= 1'b0;
      cand  <= '0;
    end else if (tick) begin
      if (din == level) begin
        cand <= '0;
      end else if (cand_inc >= need) begin
        level <= din;
        cand  <= '0;
      end else begin
        cand <= cand_inc[THR_W-1:0];
      end
    end
  end

  // R4
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(level));
endmodule

// File: rtl/irrl_run_meter.sv
module irrl_run_meter import irrl_pkg::*; #(
  parameter int IDLE_W        = 8,
  parameter int IDLE_UNIT_LOG = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              level,
  input  logic [IDLE_W-1:0] idle_thr,
  output logic              emit_v,
  output rl_byte_t          emit_d,
  output logic              flush
);
  localparam int CW = IDLE_W + IDLE_UNIT_LOG + 1;

  logic                active, act_n;
  logic                cur, cur_n;
  logic [RL_LEN_W-1:0] cnt, cnt_n, cnt_inc;
  logic [CW-1:0]       idle, idle_n, idle_inc, window;

  assign window   = (CW'(idle_thr) + CW'(1)) << IDLE_UNIT_LOG;
  assign cnt_inc  = cnt + 1'b1;
  assign idle_inc = idle + 1'b1;

  always_comb begin
    act_n  = active;
    cur_n  = cur;
    cnt_n  = cnt;
    idle_n = idle;
    emit_v = 1'b0;
    emit_d = '0;
    flush  = 1'b0;
    if (run && tick) begin
      if (!active) begin
        if (level) begin
          act_n  = 1'b1;
          cur_n  = 1'b1;
          cnt_n  = RL_LEN_W'(1);
          idle_n = '0;
        end
      end else if (level != cur) begin
        if (cnt != '0) begin
          emit_v      = 1'b1;
          emit_d.mark = cur;
          emit_d.len  = cnt;
        end
        cur_n  = level;
        cnt_n  = RL_LEN_W'(1);
        idle_n = level ? '0 : CW'(1);
      end else if (!cur && idle_inc == window) begin
        emit_v      = 1'b1;
        emit_d.mark = 1'b0;
        emit_d.len  = cnt_inc;
        flush       = 1'b1;
        act_n       = 1'b0;
        cnt_n       = '0;
        idle_n      = '0;
      end else begin
        if (!cur) idle_n = idle_inc;
        if (cnt_inc == RL_LEN_W'(RL_MAX)) begin
          emit_v      = 1'b1;
          emit_d.mark = cur;
          emit_d.len  = cnt_inc;
          cnt_n       = '0;
        end else begin
          cnt_n = cnt_inc;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      active <= 1'b0;
      cur    <= 1'b0;
      cnt    <= '0;
      idle   <= '0;
    end else begin
      active <= act_n;
      cur    <= cur_n;
      cnt    <= cnt_n;
      idle   <= idle_n;
    end
  end

  // R5
  len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt < RL_LEN_W'(RL_MAX)));

  // R10
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !active);
endmodule

// File: rtl/ir_runlen_sampler.sv
module ir_runlen_sampler import irrl_pkg::*; #(
  parameter int DIV_LOG       = 6,
  parameter int FILT_W        = 6,
  parameter int IDLE_W        = 8,
  parameter int IDLE_UNIT_LOG = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_line,
  input  logic              glob_en,
  input  logic              rx_en,
  input  logic              cfg_slow,
  input  logic              cfg_invert,
  input  logic [FILT_W-1:0] cfg_filter,
  input  logic [IDLE_W-1:0] cfg_idle,
  input  logic              smp_ready,
  output logic              smp_valid,
  output logic [RL_LEN_W:0] smp_data,
  output logic              pkt_end
);
  logic       run, tick, line_s, level, emit_v, flush, pend_q;
  logic [1:0] sync_q;
  rl_byte_t   emit_d;

  assign run    = glob_en && rx_en;
  assign line_s = sync_q[1] ^ cfg_invert;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], ir_line};
  end

  irrl_tick_div #(.DIV_LOG(DIV_LOG)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .slow(cfg_slow), .tick(tick));

  irrl_glitch_filter #(.THR_W(FILT_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
    .din(line_s), .thr(cfg_filter), .level(level));

  irrl_run_meter #(.IDLE_W(IDLE_W), .IDLE_UNIT_LOG(IDLE_UNIT_LOG)) u_meter (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .level(level),
    .idle_thr(cfg_idle), .emit_v(emit_v), .emit_d(emit_d), .flush(flush));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      smp_valid <= 1'b0;
      smp_data  <= '0;
      pend_q    <= 1'b0;
      pkt_end   <= 1'b0;
    end else begin
      if (emit_v && (!smp_valid || smp_ready)) begin
        smp_valid <= 1'b1;
        smp_data  <= emit_d;
      end else if (smp_ready) begin
        smp_valid <= 1'b0;
      end
      pend_q  <= flush;
      pkt_end <= pend_q;
    end
  end

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready && run) |=> (smp_valid && $stable(smp_data)));

  // R8
  off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!smp_valid && !pkt_end));

  // R7
  pe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> !pkt_end);

  // R2
  len_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> (smp_data[RL_LEN_W-1:0] != '0));
endmodule

// File: tb/sim_ir_runlen_sampler.sv
module sim_ir_runlen_sampler;
  logic       clk = 1'b0;
  logic       rst_n, ir_line, glob_en, rx_en, cfg_slow, cfg_invert;
  logic [5:0] cfg_filter;
  logic [7:0] cfg_idle;
  logic       smp_ready, smp_valid, pkt_end;
  logic [7:0] smp_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] got[$];
  logic [7:0] exp_q[$];
  int pe_cnt, pe_at, exp_pe;
  int seg_lvl[$];
  int seg_len[$];

  always #2 clk = ~clk;

  ir_runlen_sampler #(.DIV_LOG(3)) u0 (
    .clk(clk), .rst_n(rst_n), .ir_line(ir_line), .glob_en(glob_en),
    .rx_en(rx_en), .cfg_slow(cfg_slow), .cfg_invert(cfg_invert),
    .cfg_filter(cfg_filter), .cfg_idle(cfg_idle), .smp_ready(smp_ready),
    .smp_valid(smp_valid), .smp_data(smp_data), .pkt_end(pkt_end));

  always @(negedge clk) begin
    if (rst_n) begin
      if (smp_valid && smp_ready) got.push_back(smp_data);
      if (pkt_end) begin
        pe_cnt++;
        pe_at = got.size();
      end
    end
  end

  task automatic check(string req, string what, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic int div_now();
    return cfg_slow ? 16 : 8;
  endfunction

  function automatic int tmin();
    return (cfg_filter == 0) ? 1 : int'(cfg_filter);
  endfunction

  function automatic int window();
    return (int'(cfg_idle) + 1) * 128;
  endfunction

  task automatic seg(int lv, int n);
    seg_lvl.push_back(lv);
    seg_len.push_back(n);
  endtask

  task automatic add_chunks(int lv, int n);
    int left = n;
    while (left >= 127) begin
      exp_q.push_back({lv[0], 7'd127});
      left -= 127;
    end
    if (left > 0) exp_q.push_back({lv[0], 7'(left)});
  endtask

  // Filtered runs: a segment shorter than the filter minimum joins the run before it.
  task automatic build_expect();
    int el[$];
    int en[$];
    int first = -1;
    for (int i = 0; i < seg_lvl.size(); i++) begin
      if (el.size() > 0 && (seg_len[i] < tmin() || el[el.size()-1] == seg_lvl[i]))
        en[en.size()-1] += seg_len[i];
      else begin
        el.push_back(seg_lvl[i]);
        en.push_back(seg_len[i]);
      end
    end
    for (int i = 0; i < el.size(); i++)
      if (first < 0 && el[i] == 1) first = i;
    if (first < 0) return;
    for (int j = first; j < el.size() - 1; j++) add_chunks(el[j], en[j]);
    add_chunks(0, window());
    exp_pe = 1;
  endtask

  task automatic play(bit fresh, bit eg, bit er, bit model);
    got.delete();
    exp_q.delete();
    pe_cnt = 0;
    pe_at  = -1;
    exp_pe = 0;
    seg_lvl.push_front(8);
    seg_lvl.push_front(0);
    seg_len.push_front(8);
    seg_len.push_front(0);
    seg_lvl.delete(1);
    seg_len.delete(0);
    seg(0, window() + 4);
    if (model) build_expect();
    if (fresh) begin
      glob_en = 1'b0;
      rx_en   = 1'b0;
      ir_line = cfg_invert;
      step(3);
      glob_en = eg;
      rx_en   = er;
      step(div_now() / 2);
    end
    for (int i = 0; i < seg_lvl.size(); i++) begin
      ir_line = seg_lvl[i][0] ^ cfg_invert;
      step(seg_len[i] * div_now());
    end
    step(div_now() * 3);
    seg_lvl.delete();
    seg_len.delete();
  endtask

  task automatic compare(string req);
    int n = (got.size() < exp_q.size()) ? got.size() : exp_q.size();
    check(req, "byte count", got.size(), exp_q.size());
    for (int i = 0; i < n; i++) check(req, "byte value", got[i], exp_q[i]);
    check(req, "pkt_end pulses", pe_cnt, exp_pe);
    if (exp_pe == 1) check("R7", "bytes before pkt_end", pe_at, exp_q.size());
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      check("R7", "run completed before watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ir_line = 1'b0; glob_en = 1'b0; rx_en = 1'b0;
    cfg_slow = 1'b0; cfg_invert = 1'b0; cfg_filter = 6'd0; cfg_idle = 8'd0;
    smp_ready = 1'b1;
    step(4);
    rst_n = 1'b1;
    step(1);
    check("R8", "reset smp_valid", smp_valid, 0);
    check("R8", "reset pkt_end", pkt_end, 0);

    // R2 R6 R7: basic packet, no filtering
    seg(1, 10); seg(0, 5); seg(1, 20);
    play(1, 1, 1, 1);
    compare("R2");

    // R10: second packet without re-enable
    seg(1, 7); seg(0, 9); seg(1, 3);
    play(0, 1, 1, 1);
    compare("R10");

    // R4: glitches below the minimum, and a run exactly at it
    cfg_filter = 6'd3;
    seg(1, 12); seg(0, 2); seg(1, 6); seg(0, 3); seg(1, 4);
    play(1, 1, 1, 1);
    compare("R4");

    // R5: long runs split into 127-tick bytes
    cfg_filter = 6'd0;
    seg(1, 300); seg(0, 127); seg(1, 254);
    play(1, 1, 1, 1);
    compare("R5");

    // R7: longer idle window
    cfg_idle = 8'd1;
    seg(1, 5); seg(0, 200); seg(1, 2);
    play(1, 1, 1, 1);
    compare("R7");
    cfg_idle = 8'd0;

    // R1: slow tick
    cfg_slow = 1'b1;
    seg(1, 9); seg(0, 7); seg(1, 3);
    play(1, 1, 1, 1);
    compare("R1");
    cfg_slow = 1'b0;

    // R3: inverted line
    cfg_invert = 1'b1;
    seg(1, 10); seg(0, 5); seg(1, 20);
    play(1, 1, 1, 1);
    compare("R3");
    cfg_invert = 1'b0;

    // R6: only a glitch while idle
    cfg_filter = 6'd4;
    seg(1, 2);
    play(1, 1, 1, 1);
    compare("R6");

    // R8: one enable low at a time
    cfg_filter = 6'd0;
    seg(1, 10); seg(0, 5);
    play(1, 1, 0, 0);
    compare("R8");
    seg(1, 10); seg(0, 5);
    play(1, 0, 1, 0);
    compare("R8");

    // R9: consumer stalls, first byte held, later ones dropped
    smp_ready = 1'b0;
    seg(1, 10); seg(0, 5); seg(1, 20);
    play(1, 1, 1, 0);
    check("R9", "bytes taken while stalled", got.size(), 0);
    check("R9", "held valid", smp_valid, 1);
    check("R9", "held data", smp_data, 8'h8A);
    check("R9", "pkt_end while stalled", pe_cnt, 1);
    smp_ready = 1'b1;
    step(1);
    step(1);
    check("R9", "bytes after release", got.size(), 1);
    if (got.size() > 0) check("R9", "released data", got[0], 8'h8A);
    check("R9", "valid after release", smp_valid, 0);

    // R4 R5 sweep: filter minimum against mark length
    for (int t = 0; t < 6; t++) begin
      int tm = (t == 0) ? 1 : t;
      int lens[5] = '{0, 0, 127, 128, 254};
      lens[0] = tm;
      lens[1] = tm + 1;
      cfg_filter = 6'(t);
      for (int k = 0; k < 5; k++) begin
        seg(1, lens[k]); seg(0, tm + 4); seg(1, tm);
        play(1, 1, 1, 1);
        compare((lens[k] >= 127) ? "R5" : "R4");
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule